// File: doc/BRIEF.md
# Character LCD power-up sequencer with write port

This block brings up a 2x16 character text display that has an 8-bit parallel bus. After reset it waits out the display's power-up time. It then sends a fixed program of five configuration commands and waits a fixed interval after each one, instead of polling the display's busy flag. Each transfer drives register-select, read/write and the 8-bit data bus, and then strobes the enable line. The setup, strobe width and hold times are set by parameters.

When the program has finished, `init_done` goes high and stays high. From then on the host sends one byte per request through a valid/ready port. The byte is either a command (`req_is_data` = 0) or a character (`req_is_data` = 1). Back-pressure works as follows. `req_ready` is high only while the block is idle after initialization. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the transfer and its post-write delay have elapsed. The host must hold `req_is_data` and `req_code` stable while `req_valid` is high. A request raised while `req_ready` is low waits, or is ignored if it is withdrawn before `req_ready` comes back.

All delays are clock-cycle parameters, and their defaults are derived from the clock frequency (40 ms boot, 2 ms gap, a strobe of at least 450 ns). The data bus is released (high impedance) whenever no transfer is in progress.

Top module: `lcd_init_seq`

## Requirements
- R1: While `rst_n` is low, `lcd_en`, `init_done` and `req_ready` are low and `lcd_data` is not driven.
- R2: The first enable strobe after reset release starts no earlier than BOOT_CYC cycles and no later than BOOT_CYC+SETUP_CYC+6 cycles after release.
- R3: The first five strobes carry, in order, the bytes 0x38, 0x0C, 0x01, 0x06, 0x80, with `lcd_rs` low.
- R4: For each transfer, `lcd_rs` and `lcd_data` are valid at least SETUP_CYC cycles before `lcd_en` rises and stay unchanged while it is high. `lcd_en` is high for exactly PULSE_CYC cycles.
- R5: Between the fall of one initialization strobe and the rise of the next, at least HOLD_CYC+GAP_CYC+SETUP_CYC cycles pass, and at most 6 more than that.
- R6: `init_done` stays low until the fifth strobe has finished and at least HOLD_CYC+GAP_CYC cycles have passed since it fell. Once high, it stays high until reset.
- R7: `req_ready` is never high before `init_done`. A request that is already waiting when initialization ends is accepted once, and only after `init_done` is high.
- R8: An accepted request produces exactly one strobe carrying `req_code`, with `lcd_rs` equal to `req_is_data` (0 = command, 1 = character). Strobes come out in acceptance order.
- R9: `req_ready` is low from the cycle after acceptance until the transfer and its GAP_CYC delay are over. A request raised and withdrawn during that time produces no strobe. A valid held across acceptance is not written twice.
- R10: Once the hold time after a strobe has passed, the block stops driving `lcd_data` until the next transfer begins.
- R11: `lcd_rw` is low whenever `lcd_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host has a byte to write |
| req_ready | output | 1 | Block will accept a request on this edge |
| req_is_data | input | 1 | 1 = character byte, 0 = command byte |
| req_code | input | 8 | Byte to write |
| init_done | output | 1 | Power-up program finished |
| lcd_rs | output | 1 | Register select to the display |
| lcd_rw | output | 1 | Read/write select (always write) |
| lcd_en | output | 1 | Enable strobe |
| lcd_data | inout | 8 | Display data bus, released when idle |

## Verification
Two events can meet in one cycle: the last initialization delay runs out while a host request is already pending, and the port hands over to the host. The bench raises `req_valid` before reset is released and holds it through the whole power-up program. The scoreboard then requires that this byte arrives once, as the sixth strobe, after `init_done`. A second pairing is a new request that arrives while a strobe is in flight. The bench raises and withdraws one during a transfer, and also chains requests with `req_valid` held high across acceptance. The queue must then hold exactly one strobe per accepted request, in order.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  // Number of commands in the power-up program.
  localparam int unsigned INIT_LEN = 5;

  typedef struct packed {
    logic       is_data;
    logic [7:0] code;
  } lcd_xfer_t;

  typedef enum logic [2:0] {
    SQ_BOOT,
    SQ_ISSUE,
    SQ_XFER,
    SQ_GAP,
    SQ_READY
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phy_state_e;

  // Power-up program: 8-bit 2-line mode, display on, clear, entry mode, home.
  function automatic logic [7:0] init_cmd(input int unsigned idx);
    case (idx)
      0:       return 8'h38;
      1:       return 8'h0C;
      2:       return 8'h01;
      3:       return 8'h06;
      default: return 8'h80;
    endcase
  endfunction

endpackage

// File: rtl/lcd_delay_timer.sv
module lcd_delay_timer #(
  parameter int unsigned W        = 8,
  parameter int unsigned RST_LOAD = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         running
);

  logic [W-1:0] cnt_q;

  // Reset preloads the boot interval so the wait starts with no extra state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= W'(RST_LOAD);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign running = (cnt_q != '0);

endmodule

// File: rtl/lcd_write_phy.sv
module lcd_write_phy
  import lcd_seq_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = 23,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  lcd_xfer_t xfer,
  output logic      done,
  output logic      en,
  output logic      rs,
  output logic      oe,
  output logic [7:0] dout
);

  localparam int unsigned MAX_A = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int unsigned MAX_P = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int unsigned PW    = (MAX_P < 2) ? 1 : $clog2(MAX_P);

  phy_state_e ph_q;
  logic [PW-1:0] cnt_q;
  logic en_q, oe_q, rs_q;
  logic [7:0] dout_q;

  // All pin-facing controls are flops, so the strobe cannot glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      oe_q   <= 1'b0;
      rs_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            rs_q   <= xfer.is_data;
            dout_q <= xfer.code;
            oe_q   <= 1'b1;
            cnt_q  <= PW'(SETUP_CYC - 1);
            ph_q   <= PH_SETUP;
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            en_q  <= 1'b1;
            cnt_q <= PW'(PULSE_CYC - 1);
            ph_q  <= PH_STROBE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt_q == '0) begin
            en_q  <= 1'b0;
            cnt_q <= PW'(HOLD_CYC - 1);
            ph_q  <= PH_HOLD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            oe_q <= 1'b0;
            ph_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign done = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign en   = en_q;
  assign oe   = oe_q;
  assign rs   = rs_q;
  assign dout = dout_q;

endmodule

// File: rtl/lcd_init_fsm.sv
module lcd_init_fsm
  import lcd_seq_pkg::*;
#(
  parameter int unsigned GAP_CYC = 100000,
  parameter int unsigned TMR_W   = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_running,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val,
  input  logic             phy_done,
  output logic             phy_start,
  output lcd_xfer_t        xfer,
  input  logic             req_valid,
  input  logic             req_is_data,
  input  logic [7:0]       req_code,
  output logic             req_ready,
  output logic             init_done
);

  localparam int unsigned IDX_W = $clog2(INIT_LEN);
  localparam int unsigned LAST  = INIT_LEN - 1;

  seq_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  lcd_xfer_t xfer_q;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_BOOT;
      idx_q   <= '0;
      xfer_q  <= '{is_data: 1'b0, code: init_cmd(0)};
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_BOOT:  if (!tmr_running) state_q <= SQ_ISSUE;
        SQ_ISSUE: state_q <= SQ_XFER;
        SQ_XFER:  if (phy_done) state_q <= SQ_GAP;
        SQ_GAP: begin
          if (!tmr_running) begin
            if (done_q || (idx_q == IDX_W'(LAST))) begin
              done_q  <= 1'b1;
              state_q <= SQ_READY;
            end else begin
              idx_q   <= idx_q + 1'b1;
              xfer_q  <= '{is_data: 1'b0, code: init_cmd(32'(idx_q) + 1)};
              state_q <= SQ_ISSUE;
            end
          end
        end
        SQ_READY: begin
          if (req_valid) begin
            xfer_q  <= '{is_data: req_is_data, code: req_code};
            state_q <= SQ_ISSUE;
          end
        end
        default: state_q <= SQ_BOOT;
      endcase
    end
  end

  assign phy_start = (state_q == SQ_ISSUE);
  assign tmr_load  = (state_q == SQ_XFER) && phy_done;
  assign tmr_val   = TMR_W'(GAP_CYC);
  assign xfer      = xfer_q;
  assign req_ready = (state_q == SQ_READY);
  assign init_done = done_q;

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned BOOT_CYC  = CLK_HZ / 25,
  parameter int unsigned GAP_CYC   = CLK_HZ / 500,
  parameter int unsigned SETUP_CYC = 2,
  parameter int unsigned PULSE_CYC = ((CLK_HZ / 1_000_000) * 450 + 999) / 1000 + 1,
  parameter int unsigned HOLD_CYC  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_code,
  output logic       init_done,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  inout  wire  [7:0] lcd_data
);

  localparam int unsigned TMR_MAX = (BOOT_CYC > GAP_CYC) ? BOOT_CYC : GAP_CYC;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  logic             tmr_load, tmr_running;
  logic [TMR_W-1:0] tmr_val;
  logic             phy_start, phy_done, phy_oe;
  logic [7:0]       phy_dout;
  lcd_xfer_t        xfer;

  lcd_delay_timer #(
    .W        (TMR_W),
    .RST_LOAD (BOOT_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .running  (tmr_running)
  );

  lcd_init_fsm #(
    .GAP_CYC (GAP_CYC),
    .TMR_W   (TMR_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_running (tmr_running),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .phy_done    (phy_done),
    .phy_start   (phy_start),
    .xfer        (xfer),
    .req_valid   (req_valid),
    .req_is_data (req_is_data),
    .req_code    (req_code),
    .req_ready   (req_ready),
    .init_done   (init_done)
  );

  lcd_write_phy #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_phy (
    .clk   (clk),
    .rst_n (rst_n),
    .start (phy_start),
    .xfer  (xfer),
    .done  (phy_done),
    .en    (lcd_en),
    .rs    (lcd_rs),
    .oe    (phy_oe),
    .dout  (phy_dout)
  );

  // Only writes are issued, so the bus is driven strictly while a transfer runs.
  assign lcd_rw   = 1'b0;
  assign lcd_data = phy_oe ? phy_dout : 8'hzz;

endmodule

// File: rtl/lcd_init_seq_chk.sv
module lcd_init_seq_chk #(
  parameter int unsigned PULSE_CYC = 23
) (
  input logic       clk,
  input logic       rst_n,
  input logic       lcd_en,
  input logic       lcd_rs,
  input logic       lcd_rw,
  input logic [7:0] lcd_data,
  input logic       init_done,
  input logic       req_valid,
  input logic       req_ready
);

  localparam int unsigned CW = $clog2(PULSE_CYC + 2);

  logic [CW-1:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_run <= '0;
    else if (lcd_en) hi_run <= hi_run + 1'b1;
    else             hi_run <= '0;
  end

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_en && hi_run != '0) |-> (hi_run == CW'(PULSE_CYC)));

  assert_bus_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_en && $past(lcd_en)) |-> ($stable(lcd_data) && $stable(lcd_rs)));

  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_ready_after_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);

  assert_accept_drops_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_strobe_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !lcd_en);

  assert_write_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !lcd_rw);

endmodule

bind lcd_init_seq lcd_init_seq_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (.*);

// File: tb/tb_lcd_init_seq.sv
module tb_lcd_init_seq;

  localparam int BOOT  = 40;
  localparam int GAP   = 12;
  localparam int SETUP = 2;
  localparam int PULSE = 5;
  localparam int HOLD  = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_is_data;
  logic [7:0] req_code;
  logic req_ready, init_done, lcd_rs, lcd_rw, lcd_en;
  wire  [7:0] lcd_data;
  logic tb_drive;

  always #10 clk = ~clk;

  // The bench pulls the bus to zero only when the block must have let go of it.
  assign lcd_data = tb_drive ? 8'h00 : 8'hzz;

  lcd_init_seq #(
    .BOOT_CYC (BOOT), .GAP_CYC (GAP), .SETUP_CYC (SETUP),
    .PULSE_CYC (PULSE), .HOLD_CYC (HOLD)
  ) dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_is_data (req_is_data), .req_code (req_code), .init_done (init_done),
    .lcd_rs (lcd_rs), .lcd_rw (lcd_rw), .lcd_en (lcd_en), .lcd_data (lcd_data)
  );

  int vectors = 0;
  int errors  = 0;
  int pulse_n = 0;
  int accepted = 0;
  bit finished = 0;
  logic [8:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every strobe and times the pins.
  int cyc, hi_cnt, last_fall, stable_cnt;
  logic en_prev, done_prev;
  logic [8:0] cap, prev_bus, exp_item;
  always @(negedge clk) begin
    if (!rst_n) begin
      cyc = 0; hi_cnt = 0; last_fall = 0; stable_cnt = 0;
      en_prev = 1'b0; done_prev = 1'b0; prev_bus = '0;
    end else begin
      cyc++;
      if ({lcd_rs, lcd_data} == prev_bus) stable_cnt++;
      else stable_cnt = 0;
      prev_bus = {lcd_rs, lcd_data};
      if (lcd_en) begin
        if (!en_prev) begin
          pulse_n++;
          cap = {lcd_rs, lcd_data};
          hi_cnt = 0;
          check(lcd_rw == 1'b0, "R11", "rw during strobe", lcd_rw, 0);
          check(stable_cnt >= SETUP, "R4", "setup cycles", stable_cnt, SETUP);
          if (pulse_n == 1)
            check(cyc >= BOOT && cyc <= BOOT + SETUP + 6, "R2", "boot wait", cyc, BOOT);
          else if (pulse_n <= 5)
            check((cyc - last_fall) >= HOLD + GAP + SETUP &&
                  (cyc - last_fall) <= HOLD + GAP + SETUP + 6,
                  "R5", "command spacing", cyc - last_fall, HOLD + GAP + SETUP);
          if (exp_q.size() == 0) begin
            check(1'b0, "R8", "unexpected strobe", int'(cap), 0);
          end else begin
            exp_item = exp_q.pop_front();
            check(cap == exp_item, (pulse_n <= 5) ? "R3" : "R8", "strobe byte",
                  int'(cap), int'(exp_item));
          end
        end else begin
          check({lcd_rs, lcd_data} == cap, "R4", "bus held in strobe",
                int'({lcd_rs, lcd_data}), int'(cap));
        end
        hi_cnt++;
        check(!req_ready, "R9", "ready during strobe", req_ready, 0);
      end else if (en_prev) begin
        check(hi_cnt == PULSE, "R4", "strobe width", hi_cnt, PULSE);
        last_fall = cyc;
        if (pulse_n < 5) check(!init_done, "R6", "early init_done", init_done, 0);
      end
      if (init_done && !done_prev)
        check(pulse_n == 5 && (cyc - last_fall) >= HOLD + GAP, "R6",
              "init_done rise", cyc - last_fall, HOLD + GAP);
      if (done_prev && !init_done)
        check(1'b0, "R6", "init_done dropped", 0, 1);
      en_prev = lcd_en;
      done_prev = init_done;
    end
  end

  // Bus release: shortly after each strobe the bench may pull the bus.
  initial begin
    forever begin
      @(negedge lcd_en);
      if (rst_n) begin
        repeat (HOLD + 2) @(negedge clk);
        tb_drive = 1'b1;
        #2;
        check(lcd_data == 8'h00, "R10", "bus released", lcd_data, 0);
        tb_drive = 1'b0;
      end
    end
  end

  task automatic send_req(input bit d, input logic [7:0] b, input bit keep);
    req_is_data = d;
    req_code    = b;
    req_valid   = 1'b1;
    forever begin
      if (req_ready) break;
      @(negedge clk);
    end
    check(init_done, "R7", "accept before init_done", init_done, 1);
    exp_q.push_back({d, b});
    accepted++;
    @(negedge clk);
    if (!keep) req_valid = 1'b0;
    check(!req_ready, "R9", "ready after accept", req_ready, 0);
  endtask

  initial begin
    rst_n = 1'b0; tb_drive = 1'b1;
    req_valid = 1'b0; req_is_data = 1'b0; req_code = 8'h00;
    exp_q.push_back({1'b0, 8'h38});
    exp_q.push_back({1'b0, 8'h0C});
    exp_q.push_back({1'b0, 8'h01});
    exp_q.push_back({1'b0, 8'h06});
    exp_q.push_back({1'b0, 8'h80});
    repeat (3) @(negedge clk);
    check(!lcd_en, "R1", "reset en", lcd_en, 0);
    check(!init_done, "R1", "reset init_done", init_done, 0);
    check(!req_ready, "R1", "reset ready", req_ready, 0);
    check(lcd_data == 8'h00, "R1", "reset bus released", lcd_data, 0);
    tb_drive = 1'b0;
    // R7: request pending from before reset release, held through power-up.
    req_is_data = 1'b1; req_code = 8'h48; req_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    send_req(1'b1, 8'h48, 1'b0);
    check(pulse_n == 5, "R7", "strobes before first accept", pulse_n, 5);
    // R9: a request raised and withdrawn while busy must not be written.
    req_is_data = 1'b0; req_code = 8'hEE; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    // R8/R9: back-to-back requests with valid held across acceptance.
    while (!req_ready) @(negedge clk);
    send_req(1'b0, 8'hC0, 1'b1);
    send_req(1'b1, 8'h69, 1'b1);
    send_req(1'b1, 8'h21, 1'b0);
    while (!(req_ready && exp_q.size() == 0)) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R8", "pending strobes", exp_q.size(), 0);
    check(pulse_n == 5 + accepted, "R9", "strobe count", pulse_n, 5 + accepted);
    check(init_done, "R6", "init_done held", init_done, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule